// File: doc/BRIEF.md
# Comparator Output Sampling Filter

This block cleans up the single-bit output of an analog comparator before status or edge-detect logic uses it. The raw bit arrives asynchronously. It is brought into the bus clock domain through a short synchronizer chain and then either passed straight through, resampled once per programmable period, or debounced. In the debounced case, a new level must be seen on several successive samples before the filtered output takes it. An optional window input freezes the whole path while it is low. Software-facing logic uses it to ignore the comparator during known noisy intervals.

The two filter fields select the mode. A zero in either field gives pass-through. A count of one gives plain resampling. A larger count gives the consecutive-sample filter. The period field sets how many bus clocks separate successive samples. The period counter is internal and runs on the bus clock. Sampling from an external sample clock is not covered by this block.

Top module: `cmp_sample_filter`

## Requirements
- R1: While `rstN` is low the filtered output `filtOut` is 0, and it is still 0 at the first sample after reset is released.
- R2: When `enable` is 0 at a rising clock edge, `filtOut` is 0 after that edge, and the sample period counter and the agreement counter return to zero. After `enable` is raised, the first sample is therefore taken on the `filtPeriod`-th edge with `enable` high.
- R3: `rawIn` passes through a two-flop synchronizer. In pass-through mode a change on `rawIn` shows on `filtOut` after the third rising edge, and not after the second.
- R4: Pass-through mode applies when `filtCount` is 0 or `filtPeriod` is 0. In this mode `filtOut` takes the synchronized input on every edge that is not held.
- R5: When `filtCount` is 1 and `filtPeriod` is P (1 to 255), a sample is taken every P unheld edges, counted from the edge on which `enable` is first seen high. `filtOut` takes the sampled value on that edge. With P = 255 the change appears on edge 255 and not on edge 254.
- R6: When `filtCount` is N > 1 and `filtPeriod` is P > 0, `filtOut` changes only on a sample edge. With a steady synchronized input that disagrees with `filtOut`, the output changes on edge N*P after `enable` rises, and not on edge N*P-1.
- R7: In filtered mode, a sample that agrees with the current `filtOut` clears the agreement count. A run of fewer than N disagreeing samples leaves `filtOut` unchanged.
- R8: Gating is active when `winEnable` is 1 and `sampleSel` is 0. While gating is active and `winSignal` is 0, `filtOut` holds, input changes are ignored, and both counters hold their values.
- R9: When `winEnable` is 0 or `sampleSel` is 1, `winSignal` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawIn | input | 1 | Asynchronous comparator output bit |
| enable | input | 1 | Block enable; 0 clears output and counters |
| winEnable | input | 1 | Enables gating by `winSignal` |
| winSignal | input | 1 | Window; 0 freezes the path when gating is active |
| sampleSel | input | 1 | 1 disables window gating |
| filtPeriod | input | 8 | Bus clocks per sample; 0 selects pass-through |
| filtCount | input | 4 | Consecutive samples required; 0 pass-through, 1 resample |
| filtOut | output | 1 | Filtered comparator bit |

## Verification
Every result has a due edge that follows from the register chain:
- Pass-through output: three edges after an input change (two synchronizer flops plus the output flop).
- Clear on disable: the next edge.
- Resampled output: edge P after enable rises.
- Filtered output: edge N*P after enable rises, with each edge spent behind a closed window added on top.

The directed tests set up each case with the synchronizer already settled and `enable` low. This fixes the counter phase, so every count starts from a known edge. Each test checks the output one edge before the due edge and again on it. Inputs are driven, and the output is sampled, on falling edges.

// File: rtl/cmp_filt_pkg.sv
package cmp_filt_pkg;
  typedef struct packed {
    logic clrOut;     // force filtered output to zero
    logic loadOut;    // copy synchronized bit into output
    logic sampleTick; // a sample is taken this edge
  } ctlStrobe_t;
endpackage

// File: rtl/cmp_filt_ctrl.sv
module cmp_filt_ctrl
  import cmp_filt_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             winEnable,
  input  logic             winSignal,
  input  logic             sampleSel,
  input  logic [PER_W-1:0] filtPeriod,
  input  logic [CNT_W-1:0] filtCount,
  input  logic             mismatch,
  output ctlStrobe_t       ctl
);
  logic [PER_W-1:0] perCnt;
  logic [CNT_W-1:0] agreeCnt;
  logic gateOn, hold, bypass, perLast, commit, tick;
  logic [PER_W:0] perNext;
  logic [CNT_W:0] agreeNext;

  always_comb begin
    gateOn    = winEnable && !sampleSel;
    hold      = gateOn && !winSignal;
    bypass    = (filtCount == '0) || (filtPeriod == '0);
    perNext   = {1'b0, perCnt} + 1'b1;
    agreeNext = {1'b0, agreeCnt} + 1'b1;
    perLast   = perNext >= {1'b0, filtPeriod};
    tick      = enable && !hold && !bypass && perLast;
    commit    = tick && mismatch && (agreeNext >= {1'b0, filtCount});
    ctl.clrOut     = !enable;
    ctl.loadOut    = enable && !hold && (bypass || commit);
    ctl.sampleTick = tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt   <= '0;
      agreeCnt <= '0;
    end else if (!enable || bypass) begin
      perCnt   <= '0;
      agreeCnt <= '0;
    end else if (!hold) begin
      perCnt <= perLast ? '0 : perNext[PER_W-1:0];
      if (tick) begin
        if (!mismatch || commit) agreeCnt <= '0;
        else                     agreeCnt <= agreeNext[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cmp_filt_dp.sv
module cmp_filt_dp
  import cmp_filt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  ctlStrobe_t ctl,
  output logic       syncVal,
  output logic       mismatch,
  output logic       filtOut
);
  logic [SYNC_STAGES-1:0] syncQ;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= rawIn;
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  assign syncVal  = syncQ[SYNC_STAGES-1];
  assign mismatch = syncVal != filtOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            filtOut <= 1'b0;
    else if (ctl.clrOut)  filtOut <= 1'b0;
    else if (ctl.loadOut) filtOut <= syncVal;
  end
endmodule

// File: rtl/cmp_sample_filter.sv
module cmp_sample_filter
  import cmp_filt_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic             enable,
  input  logic             winEnable,
  input  logic             winSignal,
  input  logic             sampleSel,
  input  logic [PER_W-1:0] filtPeriod,
  input  logic [CNT_W-1:0] filtCount,
  output logic             filtOut
);
  ctlStrobe_t ctl;
  logic syncVal, mismatch, sampleTick;

  cmp_filt_ctrl #(.PER_W(PER_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .winEnable(winEnable),
    .winSignal(winSignal), .sampleSel(sampleSel), .filtPeriod(filtPeriod),
    .filtCount(filtCount), .mismatch(mismatch), .ctl(ctl)
  );

  cmp_filt_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .ctl(ctl),
    .syncVal(syncVal), .mismatch(mismatch), .filtOut(filtOut)
  );

  assign sampleTick = ctl.sampleTick;
endmodule

// File: rtl/cmp_filt_checker.sv
module cmp_filt_checker #(
  parameter int PER_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             winEnable,
  input logic             winSignal,
  input logic             sampleSel,
  input logic [PER_W-1:0] filtPeriod,
  input logic [CNT_W-1:0] filtCount,
  input logic             syncVal,
  input logic             sampleTick,
  input logic             filtOut
);
  logic closedWin, passMode;
  assign closedWin = winEnable && !sampleSel && !winSignal;
  assign passMode  = (filtCount == '0) || (filtPeriod == '0);

  assert_reset_low_R1: assert property (@(posedge clk) !rstN |=> !filtOut);

  assert_clear_when_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !filtOut);

  assert_pass_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && passMode && !closedWin) |=> (filtOut == $past(syncVal)));

  assert_resample_take_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && filtCount == 1) |=> (filtOut == $past(syncVal)));

  assert_change_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !passMode && !sampleTick) |=> $stable(filtOut));

  assert_window_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && closedWin) |=> $stable(filtOut));
endmodule

bind cmp_sample_filter cmp_filt_checker #(.PER_W(PER_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .winEnable(winEnable),
  .winSignal(winSignal), .sampleSel(sampleSel), .filtPeriod(filtPeriod),
  .filtCount(filtCount), .syncVal(syncVal), .sampleTick(sampleTick),
  .filtOut(filtOut)
);

// File: tb/sim_cmp_sample_filter.sv
`timescale 1ns/1ps
module sim_cmp_sample_filter;
  logic clk = 1'b0, rstN = 1'b0;
  logic rawIn = 1'b0, enable = 1'b0, winEnable = 1'b0, winSignal = 1'b1, sampleSel = 1'b0;
  logic [7:0] filtPeriod = 8'd0;
  logic [3:0] filtCount = 4'd0;
  logic filtOut;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmp_sample_filter u0 (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .enable(enable), .winEnable(winEnable),
    .winSignal(winSignal), .sampleSel(sampleSel), .filtPeriod(filtPeriod),
    .filtCount(filtCount), .filtOut(filtOut)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: filtOut=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // enable low, input steady high, then enable raised; returns with enable just set
  task automatic primeHigh(input logic [7:0] p, input logic [3:0] n);
    enable = 1'b0; filtPeriod = p; filtCount = n; rawIn = 1'b1;
    winEnable = 1'b0; sampleSel = 1'b0; winSignal = 1'b1;
    step(4);
    chk("R2 cleared while disabled", filtOut, 1'b0);
    enable = 1'b1;
  endtask

  task automatic testReset();
    step(3);
    chk("R1 output during reset", filtOut, 1'b0);
    rstN = 1'b1;
    step(1);
    chk("R1 output after reset", filtOut, 1'b0);
  endtask

  task automatic testSyncPass();
    enable = 1'b1; filtCount = 4'd0; filtPeriod = 8'd5; rawIn = 1'b0;
    step(5);
    rawIn = 1'b1;
    step(2);
    chk("R3 not yet after two edges", filtOut, 1'b0);
    step(1);
    chk("R3 rise after third edge", filtOut, 1'b1);
    filtCount = 4'd3; filtPeriod = 8'd0; rawIn = 1'b0;
    step(2);
    chk("R4 period zero not yet", filtOut, 1'b1);
    step(1);
    chk("R4 period zero passes through", filtOut, 1'b0);
  endtask

  task automatic testDisable();
    enable = 1'b1; filtCount = 4'd0; filtPeriod = 8'd1; rawIn = 1'b1;
    step(4);
    chk("R4 follows high input", filtOut, 1'b1);
    enable = 1'b0;
    step(1);
    chk("R2 cleared one edge after disable", filtOut, 1'b0);
  endtask

  task automatic testResample();
    primeHigh(8'd5, 4'd1);
    step(4);
    chk("R5 P=5 before sample edge", filtOut, 1'b0);
    step(1);
    chk("R5 P=5 on sample edge", filtOut, 1'b1);
    primeHigh(8'd255, 4'd1);
    step(254);
    chk("R5 P=255 edge 254", filtOut, 1'b0);
    step(1);
    chk("R5 P=255 edge 255", filtOut, 1'b1);
  endtask

  task automatic testFiltered();
    primeHigh(8'd3, 4'd4);
    step(11);
    chk("R6 N=4 P=3 edge 11", filtOut, 1'b0);
    step(1);
    chk("R6 N=4 P=3 edge 12", filtOut, 1'b1);
    primeHigh(8'd2, 4'd2);
    step(3);
    chk("R6 N=2 P=2 edge 3", filtOut, 1'b0);
    step(1);
    chk("R6 N=2 P=2 edge 4", filtOut, 1'b1);
  endtask

  task automatic testAgreeReset();
    enable = 1'b1; filtCount = 4'd3; filtPeriod = 8'd1; rawIn = 1'b0;
    winEnable = 1'b0; sampleSel = 1'b0;
    step(6);
    chk("R7 settled low", filtOut, 1'b0);
    rawIn = 1'b1;
    step(2);
    rawIn = 1'b0;
    step(10);
    chk("R7 two-sample pulse ignored", filtOut, 1'b0);
    rawIn = 1'b1;
    step(4);
    chk("R7 two disagreeing samples", filtOut, 1'b0);
    step(1);
    chk("R7 third disagreeing sample commits", filtOut, 1'b1);
  endtask

  task automatic testWindow();
    // counters frozen while closed: N=2 P=2 needs 4 running edges
    primeHigh(8'd2, 4'd2);
    winEnable = 1'b1;
    step(1);
    winSignal = 1'b0;
    step(5);
    chk("R8 held while window closed", filtOut, 1'b0);
    winSignal = 1'b1;
    step(2);
    chk("R8 counters resumed, one edge short", filtOut, 1'b0);
    step(1);
    chk("R8 change after frozen edges", filtOut, 1'b1);
    // pass-through with closed window ignores input
    filtCount = 4'd0; winSignal = 1'b0; rawIn = 1'b0;
    step(8);
    chk("R8 input change ignored", filtOut, 1'b1);
    // sampleSel disables gating
    sampleSel = 1'b1;
    step(1);
    chk("R9 sampleSel bypasses window", filtOut, 1'b0);
    sampleSel = 1'b0; winEnable = 1'b0; rawIn = 1'b1;
    step(3);
    chk("R9 winEnable low bypasses window", filtOut, 1'b1);
    winEnable = 1'b0; winSignal = 1'b1;
  endtask

  initial begin
    testReset();
    testSyncPass();
    testDisable();
    testResample();
    testFiltered();
    testAgreeReset();
    testWindow();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20000 * 5.0);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule